// File: doc/BRIEF.md
# Branch Bias Buffer for an Agree Direction Predictor

This block is a direct-mapped table that keeps one learned bias bit per branch for an agree-style direction predictor. The fetch side presents a branch PC and the sign of its displacement on a lookup stream. One cycle later it gets a response that carries three things: whether the branch is resident, whether its bias has been learned, and the bias to use. While the bias is unknown, the response falls back to a static guess taken from the displacement sign: a backward branch is guessed taken.

The execute side reports each resolved branch on a resolve stream. The first direction seen after an entry is filled becomes its bias. The bias then stays frozen until another branch that maps to the same slot evicts the entry. A lookup that misses fills the slot with an unlearned entry. A resolve that misses allocates the slot with an already-learned bias.

Both streams use valid/ready. A lookup is accepted when `lkp_valid` and `lkp_ready` are both high. `lkp_ready` is high whenever the response register is empty or is being drained in the same cycle. A response waiting under back-pressure (`rsp_valid` high, `rsp_ready` low) holds all of its fields steady. The resolve stream is never back-pressured: `res_ready` stays high.

Top module: `bias_btb`

## Requirements
- R1: After reset no entry is valid and `rsp_valid` is low, so the first lookup of any PC reports `rsp_hit`=0.
- R2: The slot index is PC bits [ALIGN_LSB+IDX_W-1:ALIGN_LSB] and the tag is the PC bits above them. A lookup hits only when the slot is valid and its tag matches, so two PCs that differ only in the tag alias the same slot.
- R3: When the bias is unknown (a miss, or a hit on an unlearned entry), `rsp_bias` equals the `lkp_disp_neg` presented with the lookup (1 = negative displacement = taken) and `rsp_known`=0.
- R4: An accepted lookup that misses fills its slot with the lookup tag and an unlearned bias, evicting any occupant. A later lookup of that PC then reports `rsp_hit`=1 and `rsp_known`=0.
- R5: A resolve that hits an unlearned entry records the outcome (`res_taken`, 1 = taken) as the bias. Later lookups report `rsp_known`=1 and `rsp_bias` equal to that outcome, whatever the displacement sign.
- R6: A resolve that misses allocates the slot, overwriting any occupant, with the bias learned from its outcome.
- R7: Once learned, a bias does not change on later resolves of the same resident branch, even when they have the opposite outcome.
- R8: After an entry is evicted and its branch returns, the bias is learned again from the branch's next first resolve.
- R9: A response appears one cycle after acceptance. While `rsp_ready` is low, the response fields hold steady, `lkp_ready` is low, and lookup inputs presented in that time are not taken.
- R10: A lookup accepted in the same cycle as a resolve to the same slot sees the state from before the resolve. When both would write the slot, the resolve's write takes effect and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request accepted this cycle when high with lkp_valid |
| lkp_pc | input | PC_W | Branch PC to look up |
| lkp_disp_neg | input | 1 | 1 when the branch displacement is negative |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Branch was resident |
| rsp_known | output | 1 | Bias came from a learned entry |
| rsp_bias | output | 1 | Bias to use, 1 = taken |
| res_valid | input | 1 | Resolved branch report valid |
| res_ready | output | 1 | Always high |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest situation to reach is a collision in one cycle: a lookup that misses and wants to fill a slot while a resolve writes that same slot. Reaching it needs both streams driven on the same clock edge with one PC. The bench does exactly that, then reads the slot back with a plain lookup to see which write survived. Eviction and relearning need two PCs that alias one slot. The bench builds them by adding DEPTH words to a PC, so the index stays the same and the tag changes.

// File: rtl/bbb_pkg.sv
package bbb_pkg;

  typedef struct packed {
    logic hit;
    logic known;
    logic bias;
  } bbb_result_t;

  function automatic bbb_result_t bbb_pick(input logic vld, input logic tag_eq,
                                           input logic known, input logic bias,
                                           input logic disp_neg);
    bbb_result_t r;
    r.hit   = vld & tag_eq;
    r.known = r.hit & known;
    r.bias  = r.known ? bias : disp_neg;
    return r;
  endfunction

endpackage

// File: rtl/bbb_split.sv
module bbb_split #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 12,
  parameter int ALIGN_LSB = 2,
  localparam int TAG_W    = PC_W - IDX_W - ALIGN_LSB
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[ALIGN_LSB +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/bbb_store.sv
module bbb_store #(
  parameter int DEPTH = 4096,
  parameter int TAG_W = 18,
  parameter int NRD   = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = TAG_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0]             rd_vld,
  output logic [NRD-1:0][TAG_W-1:0]  rd_tag,
  output logic [NRD-1:0]             rd_known,
  output logic [NRD-1:0]             rd_bias,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [TAG_W-1:0]           wtag,
  input  logic                       wknown,
  input  logic                       wbias
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {wtag, wknown, wbias};
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [ENT_W-1:0] ent;
    assign ent         = mem[rd_idx[p]];
    assign rd_vld[p]   = vld[rd_idx[p]];
    assign rd_tag[p]   = ent[ENT_W-1 -: TAG_W];
    assign rd_known[p] = ent[1];
    assign rd_bias[p]  = ent[0];
  end

  // A written slot reads back as valid on the next cycle (R4, R6)
  assert_write_sets_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> vld[$past(widx)]);
endmodule

// File: rtl/bbb_update.sv
module bbb_update #(
  parameter int IDX_W = 12,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [IDX_W-1:0] res_idx,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_taken,
  input  logic             res_hit,
  input  logic             res_known,
  input  logic             fill_req,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             we,
  output logic [IDX_W-1:0] widx,
  output logic [TAG_W-1:0] wtag,
  output logic             wknown,
  output logic             wbias
);
  logic res_wr;
  // learn on a miss or an unlearned hit; a learned resident entry is frozen
  assign res_wr = res_valid & ~(res_hit & res_known);

  always_comb begin
    we = 1'b0; widx = fill_idx; wtag = fill_tag; wknown = 1'b0; wbias = 1'b0;
    if (res_wr) begin
      we = 1'b1; widx = res_idx; wtag = res_tag; wknown = 1'b1; wbias = res_taken;
    end else if (fill_req) begin
      we = 1'b1;
    end
  end

  // A learned bias is only ever written by a resolve (R5, R6)
  assert_known_from_resolve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wknown) |-> res_valid);
  // A resolve on a learned resident entry never rewrites its slot (R7)
  assert_frozen_bias_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && res_known && we) |-> (!wknown && fill_req));
endmodule

// File: rtl/bbb_resp.sv
module bbb_resp
  import bbb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  bbb_result_t res_in,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output bbb_result_t rsp_out,
  output logic        lkp_ready
);
  assign lkp_ready = ~rsp_valid | rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_out   <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_out   <= res_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_out)));
  assert_no_accept_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lkp_ready);
  assert_known_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_out.hit || !rsp_out.known));
endmodule

// File: rtl/bias_btb.sv
module bias_btb
  import bbb_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int DEPTH     = 4096,
  parameter int ALIGN_LSB = 2,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int TAG_W    = PC_W - IDX_W - ALIGN_LSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lkp_valid,
  output logic            lkp_ready,
  input  logic [PC_W-1:0] lkp_pc,
  input  logic            lkp_disp_neg,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_hit,
  output logic            rsp_known,
  output logic            rsp_bias,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken
);
  localparam int P_LKP = 0;
  localparam int P_RES = 1;
  localparam int NRD   = 2;

  logic [NRD-1:0][PC_W-1:0]  port_pc;
  logic [NRD-1:0][IDX_W-1:0] port_idx;
  logic [NRD-1:0][TAG_W-1:0] port_tag;
  logic [NRD-1:0]            rd_vld, rd_known, rd_bias;
  logic [NRD-1:0][TAG_W-1:0] rd_tag;
  logic [NRD-1:0]            port_hit;

  assign port_pc[P_LKP] = lkp_pc;
  assign port_pc[P_RES] = res_pc;
  assign res_ready      = 1'b1;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    bbb_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)) split_i (
      .pc(port_pc[p]), .idx(port_idx[p]), .tag(port_tag[p]));
    assign port_hit[p] = rd_vld[p] & (rd_tag[p] == port_tag[p]);
  end

  logic             we, wknown, wbias;
  logic [IDX_W-1:0] widx;
  logic [TAG_W-1:0] wtag;

  bbb_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NRD(NRD)) store_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(port_idx), .rd_vld(rd_vld),
    .rd_tag(rd_tag), .rd_known(rd_known), .rd_bias(rd_bias),
    .we(we), .widx(widx), .wtag(wtag), .wknown(wknown), .wbias(wbias));

  logic        lkp_acc;
  bbb_result_t lkp_res, rsp_out;

  assign lkp_acc = lkp_valid & lkp_ready;
  assign lkp_res = bbb_pick(rd_vld[P_LKP], rd_tag[P_LKP] == port_tag[P_LKP],
                            rd_known[P_LKP], rd_bias[P_LKP], lkp_disp_neg);

  bbb_update #(.IDX_W(IDX_W), .TAG_W(TAG_W)) update_i (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_idx(port_idx[P_RES]), .res_tag(port_tag[P_RES]),
    .res_taken(res_taken), .res_hit(port_hit[P_RES]), .res_known(rd_known[P_RES]),
    .fill_req(lkp_acc & ~port_hit[P_LKP]), .fill_idx(port_idx[P_LKP]),
    .fill_tag(port_tag[P_LKP]),
    .we(we), .widx(widx), .wtag(wtag), .wknown(wknown), .wbias(wbias));

  bbb_resp resp_i (
    .clk(clk), .rst_n(rst_n), .acc(lkp_acc), .res_in(lkp_res),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_out(rsp_out),
    .lkp_ready(lkp_ready));

  assign rsp_hit   = rsp_out.hit;
  assign rsp_known = rsp_out.known;
  assign rsp_bias  = rsp_out.bias;

  // A miss result is always the displacement-sign guess (R3)
  assert_miss_uses_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_acc && !port_hit[P_LKP]) |=> (rsp_bias == $past(lkp_disp_neg)));
endmodule

// File: tb/bias_btb_tb.sv
module bias_btb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int DEPTH = 4096;
  localparam logic [31:0] ALIAS = DEPTH * 4;

  logic clk = 0, rst_n = 0;
  logic lkp_valid = 0, lkp_disp_neg = 0, rsp_ready = 1, res_valid = 0, res_taken = 0;
  logic [PC_W-1:0] lkp_pc = '0, res_pc = '0;
  logic lkp_ready, rsp_valid, rsp_hit, rsp_known, rsp_bias, res_ready;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bias_btb dut_i (.clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
    .lkp_pc(lkp_pc), .lkp_disp_neg(lkp_disp_neg), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_known(rsp_known), .rsp_bias(rsp_bias),
    .res_valid(res_valid), .res_ready(res_ready), .res_pc(res_pc), .res_taken(res_taken));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // response packed as {valid,hit,known,bias}
  function automatic logic [7:0] rsp_word();
    return {4'h0, rsp_valid, rsp_hit, rsp_known, rsp_bias};
  endfunction

  task automatic lookup(input logic [31:0] pc, input logic neg, input string req,
                        input logic h, input logic k, input logic b);
    @(negedge clk); lkp_valid = 1; lkp_pc = pc; lkp_disp_neg = neg; rsp_ready = 1;
    @(negedge clk); lkp_valid = 0;
    chk(req, rsp_word(), {4'h0, 1'b1, h, k, b});
  endtask

  task automatic resolve(input logic [31:0] pc, input logic t);
    @(negedge clk); res_valid = 1; res_pc = pc; res_taken = t;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid after reset", {7'h0, rsp_valid}, 8'h0);
    chk("R1 res_ready", {7'h0, res_ready}, 8'h1);
    lookup(32'h0000_1000, 1'b1, "R1 R3 cold miss backward", 0, 0, 1);
    lookup(32'h0000_2000, 1'b0, "R3 cold miss forward", 0, 0, 0);
  endtask

  task automatic t_fill_learn_freeze();
    lookup(32'h0000_1000, 1'b0, "R4 hit after fill unlearned", 1, 0, 0);
    resolve(32'h0000_1000, 1'b0);
    lookup(32'h0000_1000, 1'b1, "R5 learned not-taken", 1, 1, 0);
    resolve(32'h0000_1000, 1'b1);
    lookup(32'h0000_1000, 1'b1, "R7 frozen after opposite outcome", 1, 1, 0);
  endtask

  task automatic t_alias();
    lookup(32'h0000_1000 + ALIAS, 1'b1, "R2 alias misses", 0, 0, 1);
    lookup(32'h0000_1000 + ALIAS, 1'b0, "R2 R4 alias filled", 1, 0, 0);
    lookup(32'h0000_1000, 1'b0, "R2 original evicted", 0, 0, 0);
    resolve(32'h0000_1000, 1'b1);
    lookup(32'h0000_1000, 1'b0, "R8 relearned taken", 1, 1, 1);
  endtask

  task automatic t_resolve_alloc();
    resolve(32'h0000_3000, 1'b1);
    lookup(32'h0000_3000, 1'b0, "R6 resolve miss allocates", 1, 1, 1);
    resolve(32'h0000_3000 + ALIAS, 1'b0);
    lookup(32'h0000_3000 + ALIAS, 1'b1, "R6 alias overwrote", 1, 1, 0);
    resolve(32'h0000_3000, 1'b0);
    lookup(32'h0000_3000, 1'b1, "R8 relearned not-taken", 1, 1, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk); rsp_ready = 0; lkp_valid = 1; lkp_pc = 32'h0000_4000; lkp_disp_neg = 1;
    @(negedge clk);
    chk("R9 response after one cycle", rsp_word(), 8'h09);
    chk("R9 ready low while stalled", {7'h0, lkp_ready}, 8'h0);
    lkp_pc = 32'h0000_5000; lkp_disp_neg = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held response", rsp_word(), 8'h09);
    end
    rsp_ready = 1;
    @(negedge clk); lkp_valid = 0;
    chk("R9 queued lookup taken on drain", rsp_word(), 8'h08);
    @(negedge clk);
    chk("R9 drained", {7'h0, rsp_valid}, 8'h0);
    lookup(32'h0000_4000, 1'b0, "R4 stalled lookup filled", 1, 0, 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    lkp_valid = 1; lkp_pc = 32'h0000_6000; lkp_disp_neg = 0; rsp_ready = 1;
    res_valid = 1; res_pc = 32'h0000_6000; res_taken = 1;
    @(negedge clk); lkp_valid = 0; res_valid = 0;
    chk("R10 lookup sees pre-resolve state", rsp_word(), 8'h08);
    lookup(32'h0000_6000, 1'b0, "R10 resolve write wins", 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_learn_freeze();
    t_alias();
    t_resolve_alloc();
    t_backpressure();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule